// File: doc/BRIEF.md
# Receive Idle-Timeout Watcher with Receive FIFO

This block sits behind a serial receiver. The receiver pulses a strobe each time it completes a character, and the block stores that character in a small receive FIFO. An idle timer measures how long the line has been quiet since the last completed character. The timer counts oversampled baud ticks, and its limit is the time of two whole characters. When the limit is reached, a sticky timeout bit is raised in a status word. Driver software then knows that a partial burst is waiting, or that a DMA transfer should be closed.

A mode input changes the firing rule. With DMA receive selected, idle time alone sets the bit. Without DMA receive, the bit is set only if the FIFO still holds data when the limit is reached. A FIFO that is full when a character arrives drops the character and latches an overrun bit. Only a self-clearing software reset, started through the write port, recovers from that. The software reset runs for a fixed number of clock cycles and empties the FIFO, stops the timer and clears every status bit. While it runs, its busy bit reads as 1.

Top module: `uart_rx_idle_watch`

## Requirements
- R1: After `rst_ni` is released (two-stage synchronizer), `reg_rdata_o` reads 0 and `fifo_count_o` reads 0. No timeout fires before the first character has been received.
- R2: Bit 0 of `reg_rdata_o` (timeout) is set after exactly L = 2 × `frame_bits_i` × OVS cycles with `baud_tick_i` high, counted after the `frame_done_i` cycle. It becomes visible after the clock edge that samples the L-th tick, and not one tick earlier.
- R3: Each `frame_done_i` restarts the idle count from zero, including a strobe that coincides with a tick.
- R4: With `dma_mode_i` = 0, the timeout bit is set only if `fifo_count_o` is nonzero at the cycle the limit is reached. If the FIFO is empty at that moment, the expiry is consumed and no later timeout follows without a new character.
- R5: With `dma_mode_i` = 1, the timeout bit is set when the limit is reached, even with an empty FIFO.
- R6: The timeout bit is sticky. A write with `reg_wdata_i[0]` = 1 clears it. An expiry in the same cycle as the clearing write wins. After one expiry, no further timeout occurs until a new character has been received.
- R7: The FIFO returns characters in arrival order on `fifo_rdata_o` (head shown ahead of the pop). `fifo_pop_i` on an empty FIFO has no effect.
- R8: A character that arrives while `fifo_count_o` equals DEPTH is dropped and sets bit 1 (overrun). The overrun bit is not cleared by a write of `reg_wdata_i[0]`, and the FIFO contents are unchanged.
- R9: A write with `reg_wdata_i[7]` = 1 starts a software reset. Bit 7 of `reg_rdata_o` reads 1 for exactly SRST_CYC = 4 cycles and then returns to 0 by itself. Afterwards the FIFO is empty and bits 0 and 1 are clear.
- R10: A `frame_done_i` strobe in any cycle while the software reset is busy is ignored: nothing is stored and the timer is not started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick_i | input | 1 | Oversampled baud tick, one cycle per sample period |
| frame_bits_i | input | 4 | Bits per character (start, data, parity, stop) |
| dma_mode_i | input | 1 | 1 = DMA receive mode, 0 = interrupt/polled mode |
| frame_done_i | input | 1 | One-cycle strobe: a character has been received |
| frame_data_i | input | 8 | Received character, valid with frame_done_i |
| fifo_pop_i | input | 1 | Consume the FIFO head |
| fifo_rdata_o | output | 8 | FIFO head character |
| fifo_count_o | output | 3 | Number of stored characters |
| reg_wr_i | input | 1 | Write strobe for the control/status word |
| reg_wdata_i | input | 8 | Write data: bit 0 clears timeout, bit 7 starts software reset |
| reg_rdata_o | output | 8 | Status: bit 7 reset busy, bit 1 overrun, bit 0 timeout |

## Verification
An idle counter that is off by one moves the rise of the timeout bit by one tick cycle. The bench therefore checks the tick just before the limit and the tick that reaches it. A lost armed flag shows as a missing or repeated timeout a full two-character time later, and that period is stepped through in every mode. FIFO pointer or count errors show at once on the head data and the count, which are compared every cycle against a queue model. A faulty reset sequencer shows within five cycles as a wrong busy bit, or as a character stored while the reset was running.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  localparam int unsigned CTRL_CLR_BIT  = 0;
  localparam int unsigned CTRL_SRST_BIT = 7;

  typedef struct packed {
    logic       busy;
    logic [4:0] rsvd;
    logic       ovr;
    logic       tout;
  } rxto_stat_t;
endpackage

// File: rtl/rxto_fifo.sv
module rxto_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            push_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            pop_i,
  output logic [DW-1:0]   rdata_o,
  output logic [CNTW-1:0] count_o,
  output logic            full_o,
  output logic            empty_o
);
  logic [DW-1:0]   mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNTW-1:0] count_q, count_d;
  logic            push_ok, pop_ok;

  assign full_o  = (count_q == CNTW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = push_i && !full_o && !clr_i;
  assign pop_ok  = pop_i && !empty_o && !clr_i;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (clr_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_d = count_q + CNTW'(1);
        2'b01:   count_d = count_q - CNTW'(1);
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = count_q;

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNTW'(DEPTH)) else $error("fifo count above depth"); // R8
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !pop_i && !clr_i |=> full_o) else $error("full fifo lost data"); // R8
  AST_EMPTY_POP_NOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i |=> empty_o) else $error("pop on empty changed fifo"); // R7
endmodule

// File: rtl/rxto_idle_timer.sv
module rxto_idle_timer #(
  parameter int unsigned FB_W  = 4,
  parameter int unsigned OVS   = 16,
  localparam int unsigned LIM_MAX = 2 * ((1 << FB_W) - 1) * OVS,
  localparam int unsigned CW      = $clog2(LIM_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            frame_i,
  input  logic            tick_i,
  input  logic [FB_W-1:0] frame_bits_i,
  output logic            expire_o
);
  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] limit;

  assign limit    = CW'(frame_bits_i) * CW'(2 * OVS);
  assign expire_o = armed_q && tick_i && !frame_i && !clr_i
                    && (cnt_q == limit - CW'(1));

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (clr_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (frame_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && tick_i) begin
      if (expire_o) begin
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_FRAME_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && !clr_i |=> armed_q && (cnt_q == '0)) else $error("frame did not restart timer"); // R3
  AST_SINGLE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o) else $error("timer expired twice in a row"); // R6
endmodule

// File: rtl/rxto_srst_seq.sv
module rxto_srst_seq #(
  parameter int unsigned SRST_CYC = 4,
  localparam int unsigned SW      = $clog2(SRST_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [SW-1:0] cnt_q, cnt_d;

  assign busy_o = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (busy_o)       cnt_d = cnt_q - SW'(1);
    else if (start_i) cnt_d = SW'(SRST_CYC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_SRST_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o) else $error("software reset did not start"); // R9
  AST_SRST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SW'(SRST_CYC)) else $error("reset sequencer out of range"); // R9
endmodule

// File: rtl/uart_rx_idle_watch.sv
module uart_rx_idle_watch
  import rxto_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned FB_W     = 4,
  parameter int unsigned OVS      = 16,
  parameter int unsigned SRST_CYC = 4,
  localparam int unsigned CNTW    = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            baud_tick_i,
  input  logic [FB_W-1:0] frame_bits_i,
  input  logic            dma_mode_i,
  input  logic            frame_done_i,
  input  logic [DW-1:0]   frame_data_i,
  input  logic            fifo_pop_i,
  output logic [DW-1:0]   fifo_rdata_o,
  output logic [CNTW-1:0] fifo_count_o,
  input  logic            reg_wr_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o
);
  logic       rst_sync_q1, rst_sync_q2, rst_n;
  logic       busy, expire, fire, clr_req, srst_req;
  logic       fifo_full, fifo_empty;
  logic       tout_q, tout_d, ovr_q, ovr_d;
  logic       wdata_unused;
  rxto_stat_t stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q1 <= 1'b0;
      rst_sync_q2 <= 1'b0;
    end else begin
      rst_sync_q1 <= 1'b1;
      rst_sync_q2 <= rst_sync_q1;
    end
  end
  assign rst_n = rst_sync_q2;

  assign clr_req      = reg_wr_i && reg_wdata_i[CTRL_CLR_BIT];
  assign srst_req     = reg_wr_i && reg_wdata_i[CTRL_SRST_BIT];
  assign wdata_unused = ^reg_wdata_i[6:1];

  rxto_srst_seq #(.SRST_CYC(SRST_CYC)) srst_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (srst_req),
    .busy_o  (busy)
  );

  rxto_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .clr_i   (busy),
    .push_i  (frame_done_i),
    .wdata_i (frame_data_i),
    .pop_i   (fifo_pop_i),
    .rdata_o (fifo_rdata_o),
    .count_o (fifo_count_o),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  rxto_idle_timer #(.FB_W(FB_W), .OVS(OVS)) timer_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .clr_i        (busy),
    .frame_i      (frame_done_i),
    .tick_i       (baud_tick_i),
    .frame_bits_i (frame_bits_i),
    .expire_o     (expire)
  );

  assign fire = expire && (dma_mode_i || !fifo_empty);

  always_comb begin
    tout_d = tout_q;
    ovr_d  = ovr_q;
    if (busy) begin
      tout_d = 1'b0;
      ovr_d  = 1'b0;
    end else begin
      if (fire)         tout_d = 1'b1;
      else if (clr_req) tout_d = 1'b0;
      if (frame_done_i && fifo_full) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      tout_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      tout_q <= tout_d;
      ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    stat      = '0;
    stat.busy = busy;
    stat.ovr  = ovr_q;
    stat.tout = tout_q;
  end
  assign reg_rdata_o = stat;

  AST_TOUT_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(tout_q) && !$past(dma_mode_i) |-> $past(fifo_count_o) != '0)
    else $error("timeout raised with empty fifo in non-dma mode"); // R4
  AST_TOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    tout_q && !busy && !clr_req |=> tout_q) else $error("timeout dropped without clear"); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    ovr_q && !busy |=> ovr_q) else $error("overrun dropped without reset"); // R8
  AST_BUSY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy |=> !tout_q && !ovr_q && (fifo_count_o == '0)) else $error("reset left state"); // R9
endmodule

// File: tb/uart_rx_idle_watch_tb_top.sv
module uart_rx_idle_watch_tb_top;
  localparam int DEPTH = 4;
  localparam int OVS   = 16;
  localparam int SRST  = 4;

  logic       clk, rst_n;
  logic       baud_tick, dma_mode, frame_done, fifo_pop, reg_wr;
  logic [3:0] frame_bits;
  logic [7:0] frame_data, reg_wdata, reg_rdata, fifo_rdata;
  logic [2:0] fifo_count;

  int    n_vec, n_bad;
  bit    done;
  string ph;

  logic [7:0] m_q[$];
  bit m_armed, m_tout, m_ovr;
  int m_cnt, m_busy;

  uart_rx_idle_watch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(baud_tick), .frame_bits_i(frame_bits),
    .dma_mode_i(dma_mode), .frame_done_i(frame_done), .frame_data_i(frame_data),
    .fifo_pop_i(fifo_pop), .fifo_rdata_o(fifo_rdata), .fifo_count_o(fifo_count),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int lim();
    return 2 * int'(frame_bits) * OVS;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic mstep(input bit fr, input logic [7:0] d, input bit pp, input bit tk,
                       input bit wr, input logic [7:0] wd);
    int  c0;
    bit  exp_x;
    if (m_busy != 0) begin
      m_q.delete(); m_armed = 0; m_cnt = 0; m_tout = 0; m_ovr = 0;
      m_busy--;
      return;
    end
    c0    = m_q.size();
    exp_x = m_armed && tk && !fr && (m_cnt == lim() - 1);
    if (fr && c0 == DEPTH) m_ovr = 1;
    if (pp && c0 > 0) void'(m_q.pop_front());
    if (fr && c0 < DEPTH) m_q.push_back(d);
    if (fr) begin m_armed = 1; m_cnt = 0; end
    else if (m_armed && tk) begin
      if (exp_x) begin m_armed = 0; m_cnt = 0; end
      else m_cnt++;
    end
    if (exp_x && (dma_mode || c0 != 0)) m_tout = 1;
    else if (wr && wd[0]) m_tout = 0;
    if (wr && wd[7]) m_busy = SRST;
  endtask

  task automatic cyc(input bit fr, input logic [7:0] d, input bit pp, input bit tk,
                     input bit wr, input logic [7:0] wd);
    frame_done = fr; frame_data = d; fifo_pop = pp; baud_tick = tk;
    reg_wr = wr; reg_wdata = wd;
    @(posedge clk);
    mstep(fr, d, pp, tk, wr, wd);
    @(negedge clk);
    chk(ph, "status", int'(reg_rdata), int'({m_busy != 0, 5'b0, m_ovr, m_tout}));
    chk(ph, "count", int'(fifo_count), m_q.size());
    if (m_q.size() > 0) chk(ph, "head", int'(fifo_rdata), int'(m_q[0]));
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, tk, 0, 8'h00);
  endtask

  task automatic soft_reset();
    cyc(0, 8'h00, 0, 0, 1, 8'h80);
    idle(SRST, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int l;
    void'($urandom(32'h1234_5EED));
    n_vec = 0; n_bad = 0; done = 0; ph = "R1";
    rst_n = 0; baud_tick = 0; dma_mode = 0; frame_done = 0; fifo_pop = 0;
    reg_wr = 0; frame_bits = 4'd5; frame_data = 0; reg_wdata = 0;
    m_armed = 0; m_tout = 0; m_ovr = 0; m_cnt = 0; m_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3, 0);
    chk("R1", "status after reset", int'(reg_rdata), 0);
    chk("R1", "count after reset", int'(fifo_count), 0);
    idle(400, 1);
    chk("R1", "no timeout before first frame", int'(reg_rdata[0]), 0);

    // R2: exact limit
    ph = "R2"; l = lim();
    cyc(1, 8'h5A, 0, 1, 0, 0);
    idle(l - 1, 1);
    chk("R2", "timeout one tick early", int'(reg_rdata[0]), 0);
    idle(1, 1);
    chk("R2", "timeout at limit", int'(reg_rdata[0]), 1);

    // R6: clear, no refire, set beats clear
    ph = "R6";
    cyc(0, 0, 0, 0, 1, 8'h01);
    chk("R6", "cleared by write", int'(reg_rdata[0]), 0);
    idle(2 * l, 1);
    chk("R6", "no refire without frame", int'(reg_rdata[0]), 0);
    cyc(1, 8'h66, 0, 1, 0, 0);
    idle(l - 1, 1);
    cyc(0, 0, 0, 1, 1, 8'h01);
    chk("R6", "expiry wins over clear", int'(reg_rdata[0]), 1);

    // R9 / R10: software reset with frames during busy
    ph = "R9";
    cyc(0, 0, 0, 0, 1, 8'h80);
    chk("R9", "busy bit set", int'(reg_rdata[7]), 1);
    ph = "R10";
    for (int i = 0; i < SRST - 1; i++) begin
      cyc(1, 8'hC3, 0, 1, 0, 0);
      chk("R9", "busy held", int'(reg_rdata[7]), 1);
    end
    cyc(0, 0, 0, 1, 0, 0);
    chk("R9", "busy self-clears", int'(reg_rdata), 0);
    chk("R10", "frames during reset dropped", int'(fifo_count), 0);
    idle(2 * l, 1);
    chk("R10", "timer not started in reset", int'(reg_rdata[0]), 0);

    // R3: restart
    ph = "R3";
    cyc(1, 8'h01, 0, 1, 0, 0);
    idle(l - 5, 1);
    cyc(1, 8'h02, 0, 1, 0, 0);
    idle(l - 1, 1);
    chk("R3", "restarted count not expired", int'(reg_rdata[0]), 0);
    idle(1, 1);
    chk("R3", "expires after restart", int'(reg_rdata[0]), 1);
    soft_reset();

    // R4: non-DMA with empty FIFO
    ph = "R4"; dma_mode = 0;
    cyc(1, 8'h10, 0, 1, 0, 0);
    cyc(0, 0, 1, 1, 0, 0);
    idle(l, 1);
    chk("R4", "no timeout when empty", int'(reg_rdata[0]), 0);
    idle(l, 1);
    chk("R4", "expiry consumed", int'(reg_rdata[0]), 0);

    // R5: DMA with empty FIFO
    ph = "R5"; dma_mode = 1;
    cyc(1, 8'h20, 0, 1, 0, 0);
    cyc(0, 0, 1, 1, 0, 0);
    chk("R5", "fifo drained", int'(fifo_count), 0);
    idle(l, 1);
    chk("R5", "timeout in dma mode", int'(reg_rdata[0]), 1);
    soft_reset();
    dma_mode = 0;

    // R7: ordering and empty pop
    ph = "R7";
    cyc(1, 8'hA5, 0, 0, 0, 0);
    cyc(1, 8'h3C, 0, 0, 0, 0);
    cyc(1, 8'hF0, 0, 0, 0, 0);
    chk("R7", "count", int'(fifo_count), 3);
    chk("R7", "head first", int'(fifo_rdata), 8'hA5);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R7", "head second", int'(fifo_rdata), 8'h3C);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R7", "head third", int'(fifo_rdata), 8'hF0);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R7", "empty pop ignored", int'(fifo_count), 0);
    cyc(1, 8'h77, 0, 0, 0, 0);
    chk("R7", "after wrap", int'(fifo_rdata), 8'h77);
    soft_reset();

    // R8: overrun
    ph = "R8";
    for (int i = 1; i <= 5; i++) cyc(1, 8'(i * 17), 0, 0, 0, 0);
    chk("R8", "count at depth", int'(fifo_count), DEPTH);
    chk("R8", "overrun set", int'(reg_rdata[1]), 1);
    cyc(0, 0, 0, 0, 1, 8'h01);
    chk("R8", "overrun survives clear write", int'(reg_rdata[1]), 1);
    chk("R8", "oldest kept", int'(fifo_rdata), 8'h11);
    soft_reset();
    chk("R9", "reset cleared all", int'(reg_rdata), 0);
    chk("R9", "reset emptied fifo", int'(fifo_count), 0);

    // constrained random, compared against the model every cycle
    ph = "RAND";
    for (int seg = 0; seg < 4; seg++) begin
      dma_mode = seg[0];
      for (int i = 0; i < 3000; i++) begin
        bit fr, pp, tk, wr;
        logic [7:0] wd;
        fr = ($urandom % 400) == 0;
        pp = ($urandom % 6) == 0;
        tk = ($urandom % 2) == 0;
        wr = ($urandom % 250) == 0;
        wd = (($urandom % 8) == 0) ? 8'h80 : 8'h01;
        cyc(fr, 8'($urandom), pp, tk, wr, wd);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule